// File: doc/BRIEF.md
# Processor-side interrupt priority and completion unit

This unit sits between an interrupt distributor and one processing element. Each cycle it looks at the single best pending interrupt the distributor offers (identifier, priority and group) and decides whether to signal it. The decision uses three things: the group's enable bit, a software priority mask, and the current running priority. A smaller priority value is more urgent. When the processor acknowledges, the unit returns the identifier, marks it active and pushes its priority onto a small stack. The top of that stack is the running priority. When nothing qualifies, the acknowledge returns a spurious identifier and leaves all state alone.

Completion has two steps. A priority drop pops the stack, which restores the running priority that was in force before the acknowledge. A deactivation removes the interrupt from the active set and reports its identifier back to the distributor. The split-mode input decides how these steps are triggered. With it low, one end-of-interrupt write does both. With it high, the end-of-interrupt write only drops the priority, and a separate deactivate write finishes the interrupt. A binary point setting makes the low-order priority bits a subpriority, which does not count when deciding preemption.

Top module: `pe_prio_cpuif`

## Requirements
- R1: After reset, `irq_o`, `ack_valid_o` and `deact_valid_o` are 0, and `run_prio_o` is all ones, which is the idle running priority.
- R2: `irq_o` is 1 one clock after a pending interrupt is presented that meets all of the following: its group is enabled, its priority is numerically below `prio_mask_i`, it beats the running priority, and there is room to accept it. Smaller values mean higher urgency.
- R3: A pending interrupt whose group bit in `grp_en_i` is 0 never raises `irq_o`. Bit 0 of `grp_en_i` enables group 0 and bit 1 enables group 1, selected by `pend_grp_i`.
- R4: A pending priority equal to or above `prio_mask_i` never raises `irq_o`.
- R5: An acknowledge of a qualifying interrupt returns its identifier on `ack_id_o` with `ack_valid_o` one clock later. In that same clock, `run_prio_o` becomes the acknowledged priority.
- R6: An acknowledge with nothing qualifying returns identifier 1023 and leaves `run_prio_o` unchanged.
- R7: For preemption, the lowest `bin_point_i` bits of both the pending and the running priority are ignored. Only a strictly lower group value preempts, so an equal group priority does not preempt.
- R8: An end-of-interrupt write pops the most recent entry of the 4-deep priority stack, which restores the running priority in force before that acknowledge. When the stack is empty, the running priority returns to all ones.
- R9: With `eoi_split_i`=0, an end-of-interrupt write for an active identifier also deactivates it. `deact_valid_o` and `deact_id_o` then report that identifier one clock later.
- R10: With `eoi_split_i`=1, an end-of-interrupt write gives no deactivation report. A deactivate write for an active identifier then produces the report one clock later.
- R11: A deactivate write is ignored, and gives no report, in two cases: when `eoi_split_i`=0, and when the identifier is not active.
- R12: With four interrupts active, `irq_o` stays 0 even for a more urgent pending interrupt, and an acknowledge returns 1023. An end-of-interrupt write in the same cycle as an acknowledge takes precedence, and the acknowledge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_valid_i | input | 1 | Distributor offers a pending interrupt |
| pend_id_i | input | ID_W | Identifier of the offered interrupt |
| pend_prio_i | input | PRIO_W | Priority of the offered interrupt |
| pend_grp_i | input | 1 | Group of the offered interrupt |
| grp_en_i | input | 2 | Per-group signalling enables |
| prio_mask_i | input | PRIO_W | Priority mask |
| bin_point_i | input | BP_W | Number of subpriority bits |
| eoi_split_i | input | 1 | 1: separate deactivation write |
| ack_req_i | input | 1 | Acknowledge strobe |
| eoi_req_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | ID_W | Identifier written with end-of-interrupt |
| deact_req_i | input | 1 | Deactivate strobe |
| deact_id_i | input | ID_W | Identifier to deactivate |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | Acknowledge result valid |
| ack_id_o | output | ID_W | Acknowledged or spurious identifier |
| run_prio_o | output | PRIO_W | Running priority |
| deact_valid_o | output | 1 | Deactivation notification |
| deact_id_o | output | ID_W | Deactivated identifier |

## Verification
`ack_id_o`, `ack_valid_o`, `run_prio_o` and `deact_valid_o`/`deact_id_o` all settle on the first rising edge after the strobe. The bench pulses each strobe for exactly one clock and samples one time unit after that edge. `irq_o` is registered from the current inputs and stack state. The bench therefore reads it one edge after the pending inputs change. After an acknowledge or completion it takes one further step before trusting the new request level. Inputs are changed only just after an edge, so each sampled value depends on a single known edge.

// File: rtl/pe_prio_pkg.sv
package pe_prio_pkg;
  localparam int unsigned SPUR_ID = 1023;
  localparam int unsigned GRP_CNT = 2;
endpackage

// File: rtl/pe_prio_stack.sv
module pe_prio_stack #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [PRIO_W-1:0] top_prio,
  output logic              empty,
  output logic              full
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push && !full && !pop)
      prio_q[IDX_W'(cnt_q)] <= push_prio;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (pop && !empty)
      cnt_q <= cnt_q - CNT_W'(1);
    else if (push && !full)
      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign top_prio = empty ? {PRIO_W{1'b1}} : prio_q[IDX_W'(cnt_q - CNT_W'(1))];
endmodule

// File: rtl/pe_act_table.sv
module pe_act_table #(
  parameter int unsigned ID_W  = 10,
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc,
  input  logic [ID_W-1:0] alloc_id,
  input  logic            free,
  input  logic [ID_W-1:0] free_id,
  output logic            hit,
  output logic            full
);
  logic [DEPTH-1:0] valid_vec;
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] sel_vec;

  always_comb begin
    logic found;
    found   = 1'b0;
    sel_vec = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_vec[i] && !found) begin
        sel_vec[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic            v_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk) begin
      if (rst)
        v_q <= 1'b0;
      else if (free && hit_vec[s])
        v_q <= 1'b0;
      else if (alloc && sel_vec[s])
        v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (alloc && sel_vec[s])
        id_q <= alloc_id;
    end

    assign valid_vec[s] = v_q;
    assign hit_vec[s]   = v_q && (id_q == free_id);
  end

  assign hit  = |hit_vec;
  assign full = &valid_vec;
endmodule

// File: rtl/pe_prio_gate.sv
module pe_prio_gate #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned BP_W   = 3
) (
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_grp,
  input  logic [1:0]        grp_en,
  input  logic [PRIO_W-1:0] prio_mask,
  input  logic [BP_W-1:0]   bin_point,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              room,
  output logic              qualify
);
  logic [PRIO_W-1:0] gmask;
  logic              beats_run;

  assign gmask     = {PRIO_W{1'b1}} << bin_point;
  assign beats_run = (pend_prio & gmask) < (run_prio & gmask);
  assign qualify   = pend_valid && grp_en[pend_grp] && (pend_prio < prio_mask)
                     && beats_run && room;
endmodule

// File: rtl/pe_prio_cpuif.sv
module pe_prio_cpuif
  import pe_prio_pkg::*;
#(
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned BP_W   = 3,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_valid_i,
  input  logic [ID_W-1:0]   pend_id_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic              pend_grp_i,
  input  logic [1:0]        grp_en_i,
  input  logic [PRIO_W-1:0] prio_mask_i,
  input  logic [BP_W-1:0]   bin_point_i,
  input  logic              eoi_split_i,
  input  logic              ack_req_i,
  input  logic              eoi_req_i,
  input  logic [ID_W-1:0]   eoi_id_i,
  input  logic              deact_req_i,
  input  logic [ID_W-1:0]   deact_id_i,
  output logic              irq_o,
  output logic              ack_valid_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic [PRIO_W-1:0] run_prio_o,
  output logic              deact_valid_o,
  output logic [ID_W-1:0]   deact_id_o
);
  logic              stk_empty, stk_full, act_full, act_hit;
  logic [PRIO_W-1:0] top_prio;
  logic              qualify, do_ack, do_push, do_pop;
  logic              rm_req, do_free;
  logic [ID_W-1:0]   rm_id;

  assign do_ack  = ack_req_i && !eoi_req_i;
  assign do_push = do_ack && qualify;
  assign do_pop  = eoi_req_i;
  assign rm_req  = eoi_split_i ? deact_req_i : eoi_req_i;
  assign rm_id   = eoi_split_i ? deact_id_i  : eoi_id_i;
  assign do_free = rm_req && act_hit;

  pe_prio_gate #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_gate (
    .pend_valid (pend_valid_i),
    .pend_prio  (pend_prio_i),
    .pend_grp   (pend_grp_i),
    .grp_en     (grp_en_i),
    .prio_mask  (prio_mask_i),
    .bin_point  (bin_point_i),
    .run_prio   (top_prio),
    .room       (!stk_full && !act_full),
    .qualify    (qualify)
  );

  pe_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .pop       (do_pop),
    .push_prio (pend_prio_i),
    .top_prio  (top_prio),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  pe_act_table #(.ID_W(ID_W), .DEPTH(DEPTH)) u_act (
    .clk      (clk),
    .rst      (rst),
    .alloc    (do_push),
    .alloc_id (pend_id_i),
    .free     (rm_req),
    .free_id  (rm_id),
    .hit      (act_hit),
    .full     (act_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o         <= 1'b0;
      ack_valid_o   <= 1'b0;
      ack_id_o      <= ID_W'(SPUR_ID);
      deact_valid_o <= 1'b0;
      deact_id_o    <= '0;
    end else begin
      irq_o         <= qualify;
      ack_valid_o   <= do_ack;
      if (do_ack)
        ack_id_o    <= do_push ? pend_id_i : ID_W'(SPUR_ID);
      deact_valid_o <= do_free;
      if (do_free)
        deact_id_o  <= rm_id;
    end
  end

  assign run_prio_o = top_prio;

  logic unused_ok;
  assign unused_ok = stk_empty;
endmodule

// File: rtl/pe_prio_cpuif_chk.sv
module pe_prio_cpuif_chk
  import pe_prio_pkg::*;
#(
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [PRIO_W-1:0] pend_prio_i,
  input logic              pend_grp_i,
  input logic [1:0]        grp_en_i,
  input logic [PRIO_W-1:0] prio_mask_i,
  input logic              eoi_split_i,
  input logic              eoi_req_i,
  input logic              deact_req_i,
  input logic              irq_o,
  input logic              ack_valid_o,
  input logic [ID_W-1:0]   ack_id_o,
  input logic [PRIO_W-1:0] run_prio_o,
  input logic              deact_valid_o
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!irq_o && !ack_valid_o && !deact_valid_o && run_prio_o == {PRIO_W{1'b1}}));

  p_grp_gate_r3: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(grp_en_i[pend_grp_i]));

  p_mask_gate_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(pend_prio_i < prio_mask_i));

  p_ack_raises_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_valid_o && ack_id_o != ID_W'(SPUR_ID)) |-> run_prio_o < $past(run_prio_o));

  p_spur_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_valid_o && ack_id_o == ID_W'(SPUR_ID)) |-> run_prio_o == $past(run_prio_o));

  p_joint_deact_r9: assert property (@(posedge clk) disable iff (rst)
    (deact_valid_o && !$past(eoi_split_i)) |-> $past(eoi_req_i));

  p_split_deact_r10: assert property (@(posedge clk) disable iff (rst)
    (deact_valid_o && $past(eoi_split_i)) |-> $past(deact_req_i));
endmodule

bind pe_prio_cpuif pe_prio_cpuif_chk #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .pend_prio_i   (pend_prio_i),
  .pend_grp_i    (pend_grp_i),
  .grp_en_i      (grp_en_i),
  .prio_mask_i   (prio_mask_i),
  .eoi_split_i   (eoi_split_i),
  .eoi_req_i     (eoi_req_i),
  .deact_req_i   (deact_req_i),
  .irq_o         (irq_o),
  .ack_valid_o   (ack_valid_o),
  .ack_id_o      (ack_id_o),
  .run_prio_o    (run_prio_o),
  .deact_valid_o (deact_valid_o)
);

// File: tb/pe_prio_cpuif_test.sv
`timescale 1ns/1ps
module pe_prio_cpuif_test;
  localparam int ID_W = 10, PRIO_W = 8, BP_W = 3;
  localparam logic [ID_W-1:0] SPUR = 10'd1023;

  // {prio, mask, grp, grp_en, bin_point, expected irq}, idle running priority
  localparam logic [22:0] VEC [8] = '{
    {8'h10, 8'hF0, 1'b0, 2'b01, 3'd0, 1'b1},
    {8'h10, 8'hF0, 1'b1, 2'b01, 3'd0, 1'b0},
    {8'h10, 8'hF0, 1'b1, 2'b10, 3'd0, 1'b1},
    {8'hF0, 8'hF0, 1'b0, 2'b11, 3'd0, 1'b0},
    {8'hEF, 8'hF0, 1'b0, 2'b11, 3'd0, 1'b1},
    {8'h10, 8'h10, 1'b0, 2'b11, 3'd0, 1'b0},
    {8'hFE, 8'hFF, 1'b0, 2'b11, 3'd0, 1'b1},
    {8'hFE, 8'hFF, 1'b0, 2'b11, 3'd1, 1'b0}
  };
  localparam string VTAG [8] = '{"R2", "R3", "R3", "R4", "R4", "R4", "R7", "R7"};

  logic clk = 1'b0, rst = 1'b1;
  logic pend_valid_i = 1'b0, pend_grp_i = 1'b0, eoi_split_i = 1'b0;
  logic [ID_W-1:0] pend_id_i = '0, eoi_id_i = '0, deact_id_i = '0;
  logic [PRIO_W-1:0] pend_prio_i = '1, prio_mask_i = '1;
  logic [1:0] grp_en_i = 2'b11;
  logic [BP_W-1:0] bin_point_i = '0;
  logic ack_req_i = 1'b0, eoi_req_i = 1'b0, deact_req_i = 1'b0;
  logic irq_o, ack_valid_o, deact_valid_o;
  logic [ID_W-1:0] ack_id_o, deact_id_o;
  logic [PRIO_W-1:0] run_prio_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pe_prio_cpuif uut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic offer(logic [ID_W-1:0] id, logic [PRIO_W-1:0] pr);
    pend_valid_i = 1'b1; pend_id_i = id; pend_prio_i = pr;
  endtask

  task automatic do_ack();
    ack_req_i = 1'b1; step(); ack_req_i = 1'b0;
  endtask

  task automatic do_eoi(logic [ID_W-1:0] id);
    eoi_req_i = 1'b1; eoi_id_i = id; step(); eoi_req_i = 1'b0;
  endtask

  task automatic do_deact(logic [ID_W-1:0] id);
    deact_req_i = 1'b1; deact_id_i = id; step(); deact_req_i = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1", irq_o, 0);
    chk("R1", ack_valid_o, 0);
    chk("R1", deact_valid_o, 0);
    chk("R1", run_prio_o, 8'hFF);

    // Qualification table walk
    for (int i = 0; i < 8; i++) begin
      pend_valid_i = 1'b1;
      pend_id_i    = ID_W'(i + 1);
      pend_prio_i  = VEC[i][22:15];
      prio_mask_i  = VEC[i][14:7];
      pend_grp_i   = VEC[i][6];
      grp_en_i     = VEC[i][5:4];
      bin_point_i  = VEC[i][3:1];
      step();
      chk(VTAG[i], irq_o, VEC[i][0]);
    end

    // Nesting up to full depth
    prio_mask_i = 8'hFF; grp_en_i = 2'b11; bin_point_i = '0; pend_grp_i = 1'b0;
    eoi_split_i = 1'b0;
    offer(10'd40, 8'h80); step(); chk("R2", irq_o, 1);
    do_ack();
    chk("R5", ack_valid_o, 1); chk("R5", ack_id_o, 40); chk("R5", run_prio_o, 8'h80);
    offer(10'd41, 8'h80); step(); step(); chk("R7", irq_o, 0);
    offer(10'd42, 8'h40); step(); chk("R2", irq_o, 1);
    do_ack(); chk("R5", ack_id_o, 42); chk("R5", run_prio_o, 8'h40);
    offer(10'd43, 8'h20); do_ack(); chk("R5", ack_id_o, 43); chk("R5", run_prio_o, 8'h20);
    offer(10'd44, 8'h10); do_ack(); chk("R5", ack_id_o, 44); chk("R5", run_prio_o, 8'h10);
    offer(10'd45, 8'h05); step(); step(); chk("R12", irq_o, 0);
    do_ack(); chk("R12", ack_id_o, SPUR); chk("R6", run_prio_o, 8'h10);

    // Joint completion
    do_eoi(10'd44);
    chk("R9", deact_valid_o, 1); chk("R9", deact_id_o, 44); chk("R8", run_prio_o, 8'h20);

    // Split completion
    eoi_split_i = 1'b1;
    do_eoi(10'd43);
    chk("R10", deact_valid_o, 0); chk("R8", run_prio_o, 8'h40);
    do_deact(10'd43);
    chk("R10", deact_valid_o, 1); chk("R10", deact_id_o, 43);
    do_deact(10'd43);
    chk("R11", deact_valid_o, 0);
    eoi_split_i = 1'b0;
    do_deact(10'd42);
    chk("R11", deact_valid_o, 0); chk("R11", run_prio_o, 8'h40);
    do_eoi(10'd42);
    chk("R9", deact_id_o, 42); chk("R8", run_prio_o, 8'h80);

    // End-of-interrupt wins over a simultaneous acknowledge
    offer(10'd46, 8'h30);
    ack_req_i = 1'b1; do_eoi(10'd40); ack_req_i = 1'b0;
    chk("R12", ack_valid_o, 0); chk("R8", run_prio_o, 8'hFF);
    chk("R9", deact_id_o, 40);

    // Acknowledge with nothing offered
    pend_valid_i = 1'b0; step();
    do_ack(); chk("R6", ack_id_o, SPUR); chk("R6", run_prio_o, 8'hFF);

    // Subpriority ignored for preemption
    offer(10'd50, 8'h84); do_ack(); chk("R5", ack_id_o, 50);
    offer(10'd51, 8'h82); bin_point_i = 3'd3; step(); step(); chk("R7", irq_o, 0);
    bin_point_i = 3'd0; step(); chk("R7", irq_o, 1);
    do_eoi(10'd50); chk("R9", deact_id_o, 50); chk("R8", run_prio_o, 8'hFF);

    finish_up();
  end
endmodule